// File: doc/BRIEF.md
# Masked Level Interrupt Encoder

This block gathers a set of level-sensitive interrupt lines, passes each through a two-stage synchroniser, and holds the synchronised levels as the source state. A software-writable enable mask gates that state. Any unmasked active line drives a single combined interrupt output to the processor.

Software services the interrupt by reading the source offset. The read returns a small encoded vector for the highest-priority pending line. The lowest-numbered line has the highest priority. The vector is the line index plus one, shifted left by two, so it can be used directly as a word offset into a handler table. A value of zero means nothing is pending.

The register port is 16 bits wide and has two registers. The source vector sits at byte offset 0x0 and is read-only. The enable mask sits at byte offset 0x2 and is read/write. There are no states or transitions to name: the block is a fixed pipeline of synchroniser, mask gate and priority encoder.

Top module: `irq_vec_encoder`

## Requirements
- R1: Each source bit follows the level of its input line after two clock edges. A line driven before rising edge k appears in the source state and on `irq_out` after edge k+1.
- R2: The pending set is the source state ANDed with the enable mask. `irq_out` is high exactly when at least one pending bit is set.
- R3: A read at byte offset 0x0 returns (i + 1) << 2, where i is the lowest-numbered pending line. Line 0 gives 0x0004, line 4 gives 0x0014 and line 15 gives 0x0040.
- R4: A read at offset 0x0 returns 0x0000 when no line is pending.
- R5: After reset, the source state is all zero and the enable mask is 0x0010, so only line 4 is enabled.
- R6: A write at byte offset 0x2 stores all 16 bits of `reg_wdata` in the enable mask. A read at 0x2 returns the stored mask.
- R7: A mask write takes effect on `irq_out` at the same clock edge that stores it.
- R8: A write at offset 0x0 changes nothing: the mask and the source vector are unchanged.
- R9: A read at any offset other than 0x0 or 0x2 returns 0x0000. A write there has no effect.
- R10: Read data appears on `reg_rdata` after the edge that samples `reg_rd`. It holds that value until the next read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| irq_lines | input | 16 | Level-sensitive interrupt lines, asynchronous |
| reg_addr | input | 4 | Register byte offset |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Registered read data |
| irq_out | output | 1 | Combined interrupt to the processor |

## Verification
On every cycle, the assertions check four things:
- `irq_out` matches the input levels from two edges earlier, gated by the live mask.
- The mask moves only on a write to its own offset.
- Read data stays still between reads.
- Source reads return zero exactly when nothing is pending, and otherwise a word-aligned code no larger than 0x40.

Only the bench scenarios can show the exact vector values and which line wins when several are pending. The same goes for the reset value of the mask as seen through a read, and the one-edge gap where a new level is not yet visible.

// File: rtl/irq_enc_pkg.sv
package irq_enc_pkg;

    // Byte offsets of the two registers in the port window
    localparam int unsigned OFF_SOURCE = 0;
    localparam int unsigned OFF_ENABLE = 2;

    // Register selection decoded from the offset
    typedef enum logic [1:0] {
        SEL_NONE   = 2'd0,
        SEL_SOURCE = 2'd1,
        SEL_ENABLE = 2'd2
    } reg_sel_e;

endpackage

// File: rtl/irq_line_sync.sv
module irq_line_sync #(
    parameter int unsigned WIDTH  = 16,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);

    // One shift chain per line; the last stage is the source state
    for (genvar g = 0; g < WIDTH; g++) begin : g_line
        logic [STAGES-1:0] chain;

        always_ff @(posedge clk) begin
            if (rst) begin
                chain <= '0;
            end else begin
                chain <= {chain[STAGES-2:0], async_in[g]};
            end
        end

        assign sync_out[g] = chain[STAGES-1];
    end

endmodule

// File: rtl/irq_prio_vec.sv
module irq_prio_vec #(
    parameter int unsigned WIDTH  = 16,
    parameter int unsigned DATA_W = 16
) (
    input  logic [WIDTH-1:0]  pending,
    output logic              any_hit,
    output logic [DATA_W-1:0] vector
);

    localparam int unsigned IDX_W = (WIDTH > 1) ? $clog2(WIDTH) : 1;
    localparam int unsigned PAD_W = DATA_W - IDX_W - 3;
    localparam logic [IDX_W:0] ONE = 1;

    logic [IDX_W-1:0] win_idx;
    logic [IDX_W:0]   code;

    // Scan from the top down so the lowest set bit is the last to win
    always_comb begin
        any_hit = 1'b0;
        win_idx = '0;
        for (int i = WIDTH - 1; i >= 0; i--) begin
            if (pending[i]) begin
                any_hit = 1'b1;
                win_idx = IDX_W'(i);
            end
        end
    end

    assign code   = {1'b0, win_idx} + ONE;
    assign vector = any_hit ? {{PAD_W{1'b0}}, code, 2'b00} : '0;

endmodule

// File: rtl/irq_reg_port.sv
module irq_reg_port
    import irq_enc_pkg::*;
#(
    parameter int unsigned DATA_W   = 16,
    parameter int unsigned ADDR_W   = 4,
    parameter logic [15:0] RST_MASK = 16'h0010
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [DATA_W-1:0] reg_wdata,
    input  logic [DATA_W-1:0] src_vector,
    output logic [DATA_W-1:0] mask_q,
    output logic [DATA_W-1:0] reg_rdata
);

    reg_sel_e sel;
    logic [DATA_W-1:0] rd_mux;

    always_comb begin
        if (reg_addr == ADDR_W'(OFF_SOURCE)) begin
            sel = SEL_SOURCE;
        end else if (reg_addr == ADDR_W'(OFF_ENABLE)) begin
            sel = SEL_ENABLE;
        end else begin
            sel = SEL_NONE;
        end
    end

    always_comb begin
        unique case (sel)
            SEL_SOURCE: rd_mux = src_vector;
            SEL_ENABLE: rd_mux = mask_q;
            default:    rd_mux = '0;
        endcase
    end

    // Only the enable mask is writable
    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q <= DATA_W'(RST_MASK);
        end else if (reg_wr && sel == SEL_ENABLE) begin
            mask_q <= reg_wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            reg_rdata <= '0;
        end else if (reg_rd) begin
            reg_rdata <= rd_mux;
        end
    end

endmodule

// File: rtl/irq_vec_encoder.sv
module irq_vec_encoder #(
    parameter int unsigned NUM_LINES = 16,
    parameter int unsigned DATA_W    = 16,
    parameter int unsigned ADDR_W    = 4,
    parameter int unsigned SYNC_STG  = 2,
    parameter logic [15:0] RST_MASK  = 16'h0010
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NUM_LINES-1:0] irq_lines,
    input  logic [ADDR_W-1:0]    reg_addr,
    input  logic                 reg_wr,
    input  logic                 reg_rd,
    input  logic [DATA_W-1:0]    reg_wdata,
    output logic [DATA_W-1:0]    reg_rdata,
    output logic                 irq_out
);

    logic [NUM_LINES-1:0] src_q;
    logic [DATA_W-1:0]    mask_q;
    logic [NUM_LINES-1:0] pend;
    logic [DATA_W-1:0]    src_vector;
    logic                 any_pend;

    irq_line_sync #(
        .WIDTH  (NUM_LINES),
        .STAGES (SYNC_STG)
    ) u_sync (
        .clk      (clk),
        .rst      (rst),
        .async_in (irq_lines),
        .sync_out (src_q)
    );

    assign pend = src_q & mask_q[NUM_LINES-1:0];

    irq_prio_vec #(
        .WIDTH  (NUM_LINES),
        .DATA_W (DATA_W)
    ) u_prio (
        .pending (pend),
        .any_hit (any_pend),
        .vector  (src_vector)
    );

    irq_reg_port #(
        .DATA_W   (DATA_W),
        .ADDR_W   (ADDR_W),
        .RST_MASK (RST_MASK)
    ) u_regs (
        .clk        (clk),
        .rst        (rst),
        .reg_addr   (reg_addr),
        .reg_wr     (reg_wr),
        .reg_rd     (reg_rd),
        .reg_wdata  (reg_wdata),
        .src_vector (src_vector),
        .mask_q     (mask_q),
        .reg_rdata  (reg_rdata)
    );

    assign irq_out = any_pend;

endmodule

// File: rtl/irq_vec_encoder_chk.sv
module irq_vec_encoder_chk #(
    parameter int unsigned NUM_LINES = 16,
    parameter int unsigned DATA_W    = 16,
    parameter int unsigned ADDR_W    = 4,
    parameter logic [15:0] RST_MASK  = 16'h0010
) (
    input logic                 clk,
    input logic                 rst,
    input logic [NUM_LINES-1:0] irq_lines,
    input logic [ADDR_W-1:0]    reg_addr,
    input logic                 reg_wr,
    input logic                 reg_rd,
    input logic [DATA_W-1:0]    reg_rdata,
    input logic                 irq_out,
    input logic [DATA_W-1:0]    mask_q
);

    // Counts edges since reset, saturating at 3
    logic [1:0] age;

    always_ff @(posedge clk) begin
        if (rst) begin
            age <= '0;
        end else if (age != 2'd3) begin
            age <= age + 2'd1;
        end
    end

    // R1 R2
    irq_level_chk: assert property (@(posedge clk) disable iff (rst)
        (age >= 2'd2) |->
            (irq_out == (($past(irq_lines, 2) & mask_q[NUM_LINES-1:0]) != '0)));

    // R5
    mask_reset_chk: assert property (@(posedge clk)
        rst |=> (mask_q == DATA_W'(RST_MASK)));

    // R8 R9
    mask_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !(reg_wr && reg_addr == ADDR_W'(2)) |=> $stable(mask_q));

    // R4
    idle_vec_chk: assert property (@(posedge clk) disable iff (rst)
        (reg_rd && reg_addr == '0 && !irq_out) |=> (reg_rdata == '0));

    // R3
    vec_shape_chk: assert property (@(posedge clk) disable iff (rst)
        (reg_rd && reg_addr == '0 && irq_out) |=>
            (reg_rdata != '0 && reg_rdata[1:0] == 2'b00 &&
             reg_rdata <= DATA_W'((NUM_LINES) * 4)));

    // R9
    unmapped_read_chk: assert property (@(posedge clk) disable iff (rst)
        (reg_rd && reg_addr != '0 && reg_addr != ADDR_W'(2)) |=> (reg_rdata == '0));

    // R10
    rdata_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !reg_rd |=> $stable(reg_rdata));

endmodule

bind irq_vec_encoder irq_vec_encoder_chk #(
    .NUM_LINES (NUM_LINES),
    .DATA_W    (DATA_W),
    .ADDR_W    (ADDR_W),
    .RST_MASK  (RST_MASK)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .irq_lines (irq_lines),
    .reg_addr  (reg_addr),
    .reg_wr    (reg_wr),
    .reg_rd    (reg_rd),
    .reg_rdata (reg_rdata),
    .irq_out   (irq_out),
    .mask_q    (mask_q)
);

// File: tb/irq_vec_encoder_bench.sv
module irq_vec_encoder_bench;

    localparam logic [3:0] A_SRC  = 4'h0;
    localparam logic [3:0] A_MASK = 4'h2;

    typedef struct packed {
        logic [15:0] lines;
        logic [15:0] mask;
        logic [15:0] vec;
        logic        irq;
    } vec_t;

    localparam int NV = 9;
    localparam vec_t TBL [NV] = '{
        '{16'h0000, 16'hFFFF, 16'h0000, 1'b0},
        '{16'h0001, 16'hFFFF, 16'h0004, 1'b1},
        '{16'h8000, 16'hFFFF, 16'h0040, 1'b1},
        '{16'h8001, 16'hFFFF, 16'h0004, 1'b1},
        '{16'h00F0, 16'h0080, 16'h0020, 1'b1},
        '{16'h00F0, 16'h0F00, 16'h0000, 1'b0},
        '{16'h0C00, 16'h0800, 16'h0030, 1'b1},
        '{16'h0010, 16'h0010, 16'h0014, 1'b1},
        '{16'hFFFF, 16'h0000, 16'h0000, 1'b0}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] irq_lines = '0;
    logic [3:0]  reg_addr = '0;
    logic        reg_wr = 1'b0;
    logic        reg_rd = 1'b0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic        irq_out;

    int  checks = 0;
    int  errors = 0;
    bit  done = 1'b0;

    always #10 clk = ~clk;

    irq_vec_encoder u_irq_vec_encoder (
        .clk       (clk),
        .rst       (rst),
        .irq_lines (irq_lines),
        .reg_addr  (reg_addr),
        .reg_wr    (reg_wr),
        .reg_rd    (reg_rd),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .irq_out   (irq_out)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_write(input logic [3:0] a, input logic [15:0] d);
        @(negedge clk);
        reg_addr  = a;
        reg_wdata = d;
        reg_wr    = 1'b1;
        @(negedge clk);
        reg_wr    = 1'b0;
    endtask

    task automatic do_read(input logic [3:0] a, output logic [15:0] d);
        @(negedge clk);
        reg_addr = a;
        reg_rd   = 1'b1;
        @(negedge clk);
        reg_rd   = 1'b0;
        d        = reg_rdata;
    endtask

    task automatic set_lines(input logic [15:0] v);
        @(negedge clk);
        irq_lines = v;
        repeat (2) @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #(20 * 100000);
        errors++;
        checks++;
        $display("FAIL watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin
        logic [15:0] rd;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // Reset state (R5, R4)
        chk("R5 irq after reset", 16'(irq_out), 16'h0);
        do_read(A_MASK, rd);
        chk("R5 mask reset", rd, 16'h0010);
        do_read(A_SRC, rd);
        chk("R4 empty source", rd, 16'h0000);

        // Default mask enables only line 4 (R5)
        set_lines(16'h0018);
        chk("R5 line4 enabled", 16'(irq_out), 16'h1);
        do_read(A_SRC, rd);
        chk("R5 R3 line4 vector", rd, 16'h0014);
        set_lines(16'h0008);
        chk("R5 line3 masked", 16'(irq_out), 16'h0);

        // Vector table walk (R2, R3, R4)
        for (int i = 0; i < NV; i++) begin
            do_write(A_MASK, TBL[i].mask);
            set_lines(TBL[i].lines);
            chk("R2 table irq", 16'(irq_out), 16'(TBL[i].irq));
            do_read(A_SRC, rd);
            chk("R3 table vector", rd, TBL[i].vec);
        end

        // Two-edge synchroniser latency (R1)
        do_write(A_MASK, 16'hFFFF);
        set_lines(16'h0000);
        @(negedge clk);
        irq_lines = 16'h0001;
        @(negedge clk);
        chk("R1 not yet visible", 16'(irq_out), 16'h0);
        @(negedge clk);
        chk("R1 visible after two edges", 16'(irq_out), 16'h1);

        // Mask write takes effect at its own edge (R7)
        do_write(A_MASK, 16'h0000);
        chk("R7 mask off", 16'(irq_out), 16'h0);
        do_write(A_MASK, 16'h0001);
        chk("R7 mask on", 16'(irq_out), 16'h1);

        // Full-width mask readback (R6)
        do_write(A_MASK, 16'hA5C3);
        do_read(A_MASK, rd);
        chk("R6 mask readback", rd, 16'hA5C3);

        // Source offset is read-only (R8)
        do_write(A_SRC, 16'hFFFF);
        do_read(A_MASK, rd);
        chk("R8 mask untouched", rd, 16'hA5C3);
        do_read(A_SRC, rd);
        chk("R8 source unchanged", rd, 16'h0004);

        // Read data holds between reads (R10)
        set_lines(16'h0000);
        chk("R10 rdata held", reg_rdata, 16'h0004);

        // Unmapped offsets (R9)
        do_write(4'h4, 16'h0000);
        do_read(A_MASK, rd);
        chk("R9 write ignored", rd, 16'hA5C3);
        do_read(4'h6, rd);
        chk("R9 read zero", rd, 16'h0000);

        finish_run();
    end

endmodule